// File: doc/BRIEF.md
# Parallel RGB Display Timing Generator

This block produces the pixel-clock timing for a parallel RGB panel driven by a dot clock. A horizontal counter walks through each line and a vertical counter walks through each frame. Both counters start at the first clock of the horizontal sync pulse on the first line of the vertical sync pulse. From those two positions the block derives horizontal sync, vertical sync, a data-enable strobe, and the pixel and line coordinates inside the visible window.

Software supplies the timing as totals and wait counts, all measured from the start of sync. The settings are the clocks per line, the lines per frame, the two sync widths, the wait before the first visible pixel and before the first visible line, and the visible pixel and line counts. Each of the three strobes has its own polarity control. A gate holds both sync outputs at their idle level while the counters keep running.

At every frame boundary the block does two things. It raises a frame-start flag, which is cleared by writing one to the clear input. It also copies the pending buffer base address into the live base address. A launch-edge control lets the strobes and coordinates change on the falling clock edge instead of the rising one.

Top module: `rgb_timing_gen`

## Requirements
- R1: With `run` low, or during `rst`, both counters are held at position (0,0). One clock after `run` is sampled low, `hsync`, `vsync` and `de` sit at their idle levels and `px_x`/`ln_y` read 0. During `rst`, `frame_irq` and `cur_base` also clear to 0.
- R2: A line lasts `h_total` clocks. `hsync` is asserted for the first `h_sync_w` clocks of every line (positions 0 to `h_sync_w`-1).
- R3: A frame lasts `v_total` lines. `vsync` is asserted for whole lines 0 to `v_sync_w`-1, from pixel 0 of line 0 up to the last pixel of line `v_sync_w`-1.
- R4: `de` is asserted exactly when both conditions hold: `h_wait` ≤ horizontal position < `h_wait`+`h_active`, and `v_wait` ≤ vertical position < `v_wait`+`v_active`.
- R5: While `de` is asserted, `px_x` equals horizontal position minus `h_wait` and `ln_y` equals vertical position minus `v_wait`. Otherwise both read 0.
- R6: Each strobe follows its own polarity input. When `hs_pol`, `vs_pol` or `de_pol` is 1, the matching output is high when asserted. When it is 0, that output is low when asserted.
- R7: While `sync_on` is 0, `hsync` and `vsync` stay at their idle levels. The counters, `de` and the coordinates carry on unchanged.
- R8: `frame_irq` becomes 1 on the clock edge that follows the counters standing at (0,0) with `run` high. A 1 on `irq_clr` clears the flag on the next edge. If a set and a clear arrive on the same edge, the set wins.
- R9: `cur_base` loads `next_base` on the same edge that sets `frame_irq` (R8). At all other times it holds its value.
- R10: With `neg_launch` at 0, `hsync`, `vsync`, `de`, `px_x` and `ln_y` update at the rising clock edge. With `neg_launch` at 1, they show the same sequence half a clock later, updating at the falling edge.
- R11: The first output state after `run` goes high describes position (0,0). Both syncs are asserted and `frame_irq` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Counters advance while high; cleared while low |
| sync_on | input | 1 | Lets the sync strobes reach the pins |
| neg_launch | input | 1 | 1: outputs change at the falling edge |
| hs_pol | input | 1 | 1: hsync high when asserted |
| vs_pol | input | 1 | 1: vsync high when asserted |
| de_pol | input | 1 | 1: de high when asserted |
| h_total | input | HW | Clocks per line |
| h_sync_w | input | HW | Hsync width in clocks |
| h_wait | input | HW | Clocks from sync start to the first visible pixel |
| h_active | input | HW | Visible pixels per line |
| v_total | input | VW | Lines per frame |
| v_sync_w | input | VW | Vsync width in lines |
| v_wait | input | VW | Lines from sync start to the first visible line |
| v_active | input | VW | Visible lines per frame |
| irq_clr | input | 1 | Write-one-to-clear for frame_irq |
| next_base | input | AW | Pending buffer base address |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| px_x | output | HW | Pixel index inside the visible window |
| ln_y | output | VW | Line index inside the visible window |
| frame_irq | output | 1 | Frame-start flag |
| cur_base | output | AW | Live buffer base address |

## Verification
The bench uses two configurations. In the second one, the visible window ends exactly on the last clock of the line and on the last line of the frame. An off-by-one in the window compare would either truncate `de` there or extend it into the next line.

The bench holds `irq_clr` across a frame boundary. A design that let the clear beat the set would lose a frame event.

The bench drops `run` in the middle of a frame and then restarts it. A design that resumed from the old position, instead of sync start, would put sync and the coordinates out of place.

With falling-edge launch selected, the bench samples a quarter cycle after the rising edge. A design that ignored the launch control would already show the new value at that point.

// File: rtl/rgbt_pkg.sv
package rgbt_pkg;

    // Launch edge selection for the pin-facing strobes
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } launch_edge_e;

    // Asserted-sense strobe bundle carried between stages
    typedef struct packed {
        logic hs;
        logic vs;
        logic de;
    } strobe_t;

    // Converts an asserted flag into a pin level
    function automatic logic pin_level(input logic asserted, input logic active_high);
        return active_high ? asserted : ~asserted;
    endfunction

endpackage

// File: rtl/rgbt_axis_cnt.sv
// One axis position counter: wraps at total-1, advances when adv is set.
module rgbt_axis_cnt #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         adv,
    input  logic [W-1:0] total,
    output logic [W-1:0] pos,
    output logic         wrap
);
    localparam logic [W-1:0] ONE = W'(1);

    assign wrap = adv && (pos == total - ONE);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pos <= '0;
        end else if (adv) begin
            pos <= wrap ? '0 : pos + ONE;
        end
    end

    a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !run |=> pos == '0);
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (run && wrap) |=> pos == '0);
    a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
        (run && adv && !wrap) |=> pos == $past(pos) + ONE);
    a_r3_hold_without_adv: assert property (@(posedge clk) disable iff (rst)
        (run && !adv) |=> pos == $past(pos));

endmodule

// File: rtl/rgbt_window.sv
// Decodes one axis position into sync, visible-window and offset terms.
module rgbt_window #(
    parameter int W = 12
) (
    input  logic [W-1:0] pos,
    input  logic [W-1:0] sync_w,
    input  logic [W-1:0] start,
    input  logic [W-1:0] len,
    output logic         in_sync,
    output logic         in_act,
    output logic [W-1:0] offset
);
    localparam int EW = W + 1;

    logic [EW-1:0] stop;

    always_comb begin
        stop    = {1'b0, start} + {1'b0, len};
        in_sync = pos < sync_w;
        in_act  = (pos >= start) && ({1'b0, pos} < stop);
        offset  = in_act ? (pos - start) : '0;
    end

endmodule

// File: rtl/rgbt_out_stage.sv
// Registers strobes and coordinates, applies launch edge and polarity,
// and keeps the frame flag and the live base address.
module rgbt_out_stage
    import rgbt_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 12,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          sync_on,
    input  logic          neg_launch,
    input  logic          hs_pol,
    input  logic          vs_pol,
    input  logic          de_pol,
    input  logic          h_sync,
    input  logic          v_sync,
    input  logic          h_act,
    input  logic          v_act,
    input  logic [HW-1:0] h_off,
    input  logic [VW-1:0] v_off,
    input  logic          frame_start,
    input  logic          irq_clr,
    input  logic [AW-1:0] next_base,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [HW-1:0] px_x,
    output logic [VW-1:0] ln_y,
    output logic          frame_irq,
    output logic [AW-1:0] cur_base
);
    strobe_t       rise_q, fall_q, pick;
    logic [HW-1:0] px_rise, px_fall, px_pick;
    logic [VW-1:0] ln_rise, ln_fall, ln_pick;
    logic          vis;
    launch_edge_e  edge_sel;

    assign vis      = run && h_act && v_act;
    assign edge_sel = launch_edge_e'(neg_launch);

    // Rising-edge capture of the decoded position
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            rise_q  <= '0;
            px_rise <= '0;
            ln_rise <= '0;
        end else begin
            rise_q.hs <= sync_on && h_sync;
            rise_q.vs <= sync_on && v_sync;
            rise_q.de <= vis;
            px_rise   <= vis ? h_off : '0;
            ln_rise   <= vis ? v_off : '0;
        end
    end

    // Half-cycle retimed copy for falling-edge launch
    always_ff @(negedge clk) begin
        if (rst) begin
            fall_q  <= '0;
            px_fall <= '0;
            ln_fall <= '0;
        end else begin
            fall_q  <= rise_q;
            px_fall <= px_rise;
            ln_fall <= ln_rise;
        end
    end

    always_comb begin
        if (edge_sel == EDGE_FALL) begin
            pick    = fall_q;
            px_pick = px_fall;
            ln_pick = ln_fall;
        end else begin
            pick    = rise_q;
            px_pick = px_rise;
            ln_pick = ln_rise;
        end
    end

    assign hsync = pin_level(pick.hs, hs_pol);
    assign vsync = pin_level(pick.vs, vs_pol);
    assign de    = pin_level(pick.de, de_pol);
    assign px_x  = px_pick;
    assign ln_y  = ln_pick;

    // Frame flag (set wins over clear) and live base swap
    always_ff @(posedge clk) begin
        if (rst) begin
            frame_irq <= 1'b0;
            cur_base  <= '0;
        end else begin
            if (frame_start) begin
                frame_irq <= 1'b1;
                cur_base  <= next_base;
            end else if (irq_clr) begin
                frame_irq <= 1'b0;
            end
        end
    end

    a_r8_flag_set: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> frame_irq);
    a_r8_flag_clear: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && irq_clr) |=> !frame_irq);
    a_r9_base_load: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> cur_base == $past(next_base));
    a_r9_base_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(cur_base));
    a_r7_sync_gate: assert property (@(posedge clk) disable iff (rst)
        !sync_on |=> (!rise_q.hs && !rise_q.vs));
    a_r1_idle_strobes: assert property (@(posedge clk) disable iff (rst)
        !run |=> (rise_q == '0 && px_rise == '0 && ln_rise == '0));

endmodule

// File: rtl/rgb_timing_gen.sv
module rgb_timing_gen #(
    parameter int HW = 12,
    parameter int VW = 12,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          sync_on,
    input  logic          neg_launch,
    input  logic          hs_pol,
    input  logic          vs_pol,
    input  logic          de_pol,
    input  logic [HW-1:0] h_total,
    input  logic [HW-1:0] h_sync_w,
    input  logic [HW-1:0] h_wait,
    input  logic [HW-1:0] h_active,
    input  logic [VW-1:0] v_total,
    input  logic [VW-1:0] v_sync_w,
    input  logic [VW-1:0] v_wait,
    input  logic [VW-1:0] v_active,
    input  logic          irq_clr,
    input  logic [AW-1:0] next_base,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [HW-1:0] px_x,
    output logic [VW-1:0] ln_y,
    output logic          frame_irq,
    output logic [AW-1:0] cur_base
);
    logic [HW-1:0] h_pos, h_off;
    logic [VW-1:0] v_pos, v_off;
    logic          h_wrap, v_wrap;
    logic          h_sync, v_sync, h_act, v_act;
    logic          frame_start;

    rgbt_axis_cnt #(.W(HW)) u_hcnt (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .adv   (1'b1),
        .total (h_total),
        .pos   (h_pos),
        .wrap  (h_wrap)
    );

    rgbt_axis_cnt #(.W(VW)) u_vcnt (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .adv   (h_wrap),
        .total (v_total),
        .pos   (v_pos),
        .wrap  (v_wrap)
    );

    rgbt_window #(.W(HW)) u_hwin (
        .pos     (h_pos),
        .sync_w  (h_sync_w),
        .start   (h_wait),
        .len     (h_active),
        .in_sync (h_sync),
        .in_act  (h_act),
        .offset  (h_off)
    );

    rgbt_window #(.W(VW)) u_vwin (
        .pos     (v_pos),
        .sync_w  (v_sync_w),
        .start   (v_wait),
        .len     (v_active),
        .in_sync (v_sync),
        .in_act  (v_act),
        .offset  (v_off)
    );

    assign frame_start = run && (h_pos == '0) && (v_pos == '0);

    rgbt_out_stage #(.HW(HW), .VW(VW), .AW(AW)) u_out (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .sync_on     (sync_on),
        .neg_launch  (neg_launch),
        .hs_pol      (hs_pol),
        .vs_pol      (vs_pol),
        .de_pol      (de_pol),
        .h_sync      (h_sync),
        .v_sync      (v_sync),
        .h_act       (h_act),
        .v_act       (v_act),
        .h_off       (h_off),
        .v_off       (v_off),
        .frame_start (frame_start),
        .irq_clr     (irq_clr),
        .next_base   (next_base),
        .hsync       (hsync),
        .vsync       (vsync),
        .de          (de),
        .px_x        (px_x),
        .ln_y        (ln_y),
        .frame_irq   (frame_irq),
        .cur_base    (cur_base)
    );

    // R3: the vertical position only moves on the last clock of a line
    a_r3_line_step: assert property (@(posedge clk) disable iff (rst)
        (run && !h_wrap) |=> v_pos == $past(v_pos));

endmodule

// File: tb/rgb_timing_gen_test.sv
`timescale 1ns/1ps
module rgb_timing_gen_test;
    localparam int HW = 12;
    localparam int VW = 12;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          run = 1'b0;
    logic          sync_on = 1'b1;
    logic          neg_launch = 1'b0;
    logic          hs_pol = 1'b1;
    logic          vs_pol = 1'b1;
    logic          de_pol = 1'b1;
    logic [HW-1:0] h_total = 12, h_sync_w = 2, h_wait = 4, h_active = 6;
    logic [VW-1:0] v_total = 8, v_sync_w = 1, v_wait = 3, v_active = 4;
    logic          irq_clr = 1'b0;
    logic [AW-1:0] next_base = 32'h1000_0000;
    logic          hsync, vsync, de, frame_irq;
    logic [HW-1:0] px_x;
    logic [VW-1:0] ln_y;
    logic [AW-1:0] cur_base;

    int checks = 0;
    int errors = 0;
    int de_cnt = 0, hs_cnt = 0, vs_cnt = 0, hs_moves = 0;
    logic last_hs = 1'b0;

    always #10 clk = ~clk;

    rgb_timing_gen #(.HW(HW), .VW(VW), .AW(AW)) uut (
        .clk(clk), .rst(rst), .run(run), .sync_on(sync_on), .neg_launch(neg_launch),
        .hs_pol(hs_pol), .vs_pol(vs_pol), .de_pol(de_pol),
        .h_total(h_total), .h_sync_w(h_sync_w), .h_wait(h_wait), .h_active(h_active),
        .v_total(v_total), .v_sync_w(v_sync_w), .v_wait(v_wait), .v_active(v_active),
        .irq_clr(irq_clr), .next_base(next_base),
        .hsync(hsync), .vsync(vsync), .de(de), .px_x(px_x), .ln_y(ln_y),
        .frame_irq(frame_irq), .cur_base(cur_base)
    );

    // Reference position model built from the requirements
    int mh = 0, mv = 0;
    logic e_hs = 0, e_vs = 0, e_de = 0, p_hs = 0, p_vs = 0, p_de = 0;
    int e_px = 0, e_ln = 0, p_px = 0, p_ln = 0;
    logic e_irq = 0;
    logic [AW-1:0] e_cur = '0;

    function automatic bit in_span(int p, int s, int l);
        return (p >= s) && (p < s + l);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mh <= 0; mv <= 0;
            e_hs <= 0; e_vs <= 0; e_de <= 0; e_px <= 0; e_ln <= 0;
            p_hs <= 0; p_vs <= 0; p_de <= 0; p_px <= 0; p_ln <= 0;
            e_irq <= 0; e_cur <= '0;
        end else begin
            p_hs <= e_hs; p_vs <= e_vs; p_de <= e_de; p_px <= e_px; p_ln <= e_ln;
            if (run) begin
                e_hs <= sync_on && (mh < int'(h_sync_w));
                e_vs <= sync_on && (mv < int'(v_sync_w));
                e_de <= in_span(mh, int'(h_wait), int'(h_active)) && in_span(mv, int'(v_wait), int'(v_active));
                e_px <= (in_span(mh, int'(h_wait), int'(h_active)) && in_span(mv, int'(v_wait), int'(v_active))) ? mh - int'(h_wait) : 0;
                e_ln <= (in_span(mh, int'(h_wait), int'(h_active)) && in_span(mv, int'(v_wait), int'(v_active))) ? mv - int'(v_wait) : 0;
                if (mh == int'(h_total) - 1) begin
                    mh <= 0;
                    mv <= (mv == int'(v_total) - 1) ? 0 : mv + 1;
                end else begin
                    mh <= mh + 1;
                end
            end else begin
                mh <= 0; mv <= 0;
                e_hs <= 0; e_vs <= 0; e_de <= 0; e_px <= 0; e_ln <= 0;
            end
            if (run && mh == 0 && mv == 0) begin
                e_irq <= 1'b1;
                e_cur <= next_base;
            end else if (irq_clr) begin
                e_irq <= 1'b0;
            end
        end
    end

    task automatic chk(bit ok, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic logic lvl(logic a, logic pol);
        return pol ? a : ~a;
    endfunction

    task automatic cmp(bit early);
        bit   up = early && neg_launch;
        logic x_hs = up ? p_hs : e_hs;
        logic x_vs = up ? p_vs : e_vs;
        logic x_de = up ? p_de : e_de;
        int   x_px = up ? p_px : e_px;
        int   x_ln = up ? p_ln : e_ln;
        chk(hsync === lvl(x_hs, hs_pol), up ? "R10 hsync" : "R2 hsync", hsync, lvl(x_hs, hs_pol));
        chk(vsync === lvl(x_vs, vs_pol), up ? "R10 vsync" : "R3 vsync", vsync, lvl(x_vs, vs_pol));
        chk(de === lvl(x_de, de_pol), up ? "R10 de" : "R4 de", de, lvl(x_de, de_pol));
        chk(int'(px_x) == x_px && !$isunknown(px_x), up ? "R10 px_x" : "R5 px_x", px_x, x_px);
        chk(int'(ln_y) == x_ln && !$isunknown(ln_y), up ? "R10 ln_y" : "R5 ln_y", ln_y, x_ln);
        chk(frame_irq === e_irq, "R8 frame_irq", frame_irq, e_irq);
        chk(cur_base === e_cur, "R9 cur_base", cur_base, e_cur);
    endtask

    task automatic clear_counts();
        de_cnt = 0; hs_cnt = 0; vs_cnt = 0; hs_moves = 0; last_hs = hsync;
    endtask

    // Returns at rising edge + 15 ns, where inputs may be changed safely
    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #5;
            cmp(1'b1);
            #10;
            cmp(1'b0);
            if (de === de_pol) de_cnt++;
            if (hsync === hs_pol) hs_cnt++;
            if (vsync === vs_pol) vs_cnt++;
            if (hsync !== last_hs) hs_moves++;
            last_hs = hsync;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(3);
        chk(hsync === 1'b0 && vsync === 1'b0 && de === 1'b0, "R1 reset strobes idle", {hsync, vsync, de}, 0);
        chk(px_x == '0 && ln_y == '0, "R1 reset coordinates", px_x + ln_y, 0);
        chk(frame_irq === 1'b0 && cur_base === '0, "R1 reset flag and base", frame_irq, 0);
        rst = 1'b0;
        step(2);
    endtask

    task automatic t_basic();
        clear_counts();
        run = 1'b1;
        step(1);
        chk(hsync === 1'b1 && vsync === 1'b1, "R11 first state in sync", {hsync, vsync}, 3);
        chk(frame_irq === 1'b1, "R11 first state flag", frame_irq, 1);
        chk(cur_base === 32'h1000_0000, "R9 first base", cur_base, 32'h1000_0000);
        step(2 * 96 - 1);
        chk(de_cnt == 2 * 24, "R4 visible count", de_cnt, 48);
        chk(hs_cnt == 2 * 16, "R2 hsync clocks", hs_cnt, 32);
        chk(vs_cnt == 2 * 12, "R3 vsync clocks", vs_cnt, 24);
    endtask

    task automatic t_polarity();
        hs_pol = 1'b0; vs_pol = 1'b1; de_pol = 1'b0;
        clear_counts();
        step(96);
        chk(hs_cnt == 16, "R6 low hsync clocks", hs_cnt, 16);
        chk(de_cnt == 24, "R6 low de clocks", de_cnt, 24);
        chk(vs_cnt == 12, "R6 high vsync clocks", vs_cnt, 12);
        hs_pol = 1'b1; de_pol = 1'b1;
        step(4);
    endtask

    task automatic t_gate();
        sync_on = 1'b0;
        step(1);
        clear_counts();
        step(96);
        chk(hs_moves == 0 && hsync === 1'b0, "R7 hsync held idle", hs_moves, 0);
        chk(vs_cnt == 0, "R7 vsync held idle", vs_cnt, 0);
        chk(de_cnt == 24, "R7 de keeps running", de_cnt, 24);
        sync_on = 1'b1;
        step(4);
    endtask

    task automatic t_irq_base();
        // Wait for a clock with no frame start pending, then clear
        while (mh == 0 && mv == 0) step(1);
        irq_clr = 1'b1;
        step(1);
        irq_clr = 1'b0;
        chk(frame_irq === 1'b0, "R8 cleared by write", frame_irq, 0);
        next_base = 32'h2000_0040;
        step(1);
        chk(cur_base === 32'h1000_0000, "R9 base held mid-frame", cur_base, 32'h1000_0000);
        step(96);
        chk(frame_irq === 1'b1, "R8 set at next frame", frame_irq, 1);
        chk(cur_base === 32'h2000_0040, "R9 base swapped", cur_base, 32'h2000_0040);
        irq_clr = 1'b1;
        step(200);
        irq_clr = 1'b0;
        step(2);
    endtask

    task automatic t_run_drop();
        step(37);
        run = 1'b0;
        step(1);
        chk(hsync === 1'b0 && vsync === 1'b0 && de === 1'b0, "R1 idle after stop", {hsync, vsync, de}, 0);
        chk(px_x == '0 && ln_y == '0, "R1 coordinates after stop", px_x + ln_y, 0);
        step(5);
        run = 1'b1;
        step(1);
        chk(hsync === 1'b1 && vsync === 1'b1, "R11 restart at sync start", {hsync, vsync}, 3);
        step(150);
    endtask

    task automatic t_neg();
        neg_launch = 1'b1;
        step(200);
        neg_launch = 1'b0;
        step(4);
    endtask

    task automatic t_edge_cfg();
        run = 1'b0;
        step(1);
        h_total = 7; h_sync_w = 1; h_wait = 1; h_active = 6;
        v_total = 5; v_sync_w = 2; v_wait = 2; v_active = 3;
        run = 1'b1;
        clear_counts();
        step(70);
        chk(de_cnt == 36, "R4 window at line end", de_cnt, 36);
        chk(hs_cnt == 10, "R2 one-clock hsync", hs_cnt, 10);
        chk(vs_cnt == 28, "R3 two-line vsync", vs_cnt, 28);
        neg_launch = 1'b1;
        step(35);
        neg_launch = 1'b0;
        step(2);
    endtask

    initial begin
        #(20ns * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_polarity();
        t_gate();
        t_irq_base();
        t_run_drop();
        t_neg();
        t_edge_cfg();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule